// File: doc/BRIEF.md
# Pipelined Converter Code Aligner and Redundancy Combiner

Each stage of a pipelined analog-to-digital converter hands over a short decision code every clock. Because the stages behave like a shift register, the codes that describe one input sample arrive skewed in time. The first stage resolves sample n while the stage after it is still resolving the residue of sample n-1, and so on down the chain. This block receives all stage codes side by side on one bus and delays each lane by a different amount, so that every code of one sample lines up in the same cycle. It then merges the aligned codes into a single output word.

The stages carry redundancy: their inter-stage gain is below two to the power of the code width, so neighbouring codes overlap. For that reason the merge is a shifted addition with an overlap of OVERLAP bits, not a concatenation. Because of the addition, a first-stage comparator threshold that drifts by a fraction of the stage range still produces the correct final word. The sum is clipped to the largest representable word. One word leaves per clock after a fixed fill latency, and a valid flag travels with the data. The stage count, code width and overlap are parameters. An overlap of zero selects plain concatenation.

Top module: `adc_stage_combiner`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_word` is 0.
- R2: `out_valid` is high exactly NUM_STAGES clock cycles after each cycle in which `in_valid` is high, and in no other cycle.
- R3: Lane i of `stage_codes` occupies bits [i*CODE_W +: CODE_W]. The code of stage i that belongs to a sample is presented i cycles after that sample's stage-0 code, together with the `in_valid` of the stage-0 code. Codes on a lane in other cycles do not affect that sample's word.
- R4: With OVERLAP > 0, the word is the sum over stages of code_i * 2^((CODE_W-OVERLAP)*(NUM_STAGES-1-i)). Stage 0 carries the largest weight. With the defaults (4 stages, 2-bit codes, overlap 1) the weights are 8, 4, 2, 1 for stages 0 to 3.
- R5: OUT_W = (CODE_W-OVERLAP)*(NUM_STAGES-1)+CODE_W (5 with the defaults). A sum above 2^OUT_W-1 is reported as 2^OUT_W-1 (31 with the defaults).
- R6: `out_word` keeps its previous value in every cycle in which `out_valid` is low.
- R7: Samples presented on consecutive cycles produce words on consecutive cycles, in presentation order.
- R8: Codes from stages with 1.5-bit decisions produce the word floor(2^(OUT_W-1)*(v+1)) for a normalized input v in [-1,1). The decision levels are at -1/4 and +1/4, the codes are 0, 1 and 2, and the residue is 2v-(code-1). The last stage is a 2-bit quantizer floor(2*(r+1)). The word is the same when every stage's decision levels shift together by up to ±3/16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the cycle carrying a new sample's stage-0 code |
| stage_codes | input | NUM_STAGES*CODE_W | All stage codes, lane i at bits [i*CODE_W +: CODE_W] |
| out_valid | output | 1 | A merged word is present |
| out_word | output | OUT_W | Corrected, clipped output word |

## Verification
In every cycle of a continuous stream, a new sample's stage-0 code enters while an older sample's last-stage code completes its word. Alignment of the entering sample and merging of the leaving one therefore fall in the same cycle. The bench provokes this by streaming back-to-back samples, including clipped words directly next to unclipped ones and samples coded under shifted decision levels. Gap slots carry junk codes on all lanes. A scoreboard judges each word against a value computed from the analog model or the weight formula, and it checks the exact arrival cycle. A lane mixed up with a neighbouring sample shows as a wrong word, and a mismatch in delay depth shows as a wrong arrival cycle.

// File: rtl/adcal_pkg.sv
package adcal_pkg;

   // Width of the merged word for a given stage count, code width and overlap.
   function automatic int word_width(input int n_stages, input int code_w, input int overlap);
      return (code_w - overlap) * (n_stages - 1) + code_w;
   endfunction

   // Register depth applied to a lane so that it meets the last stage.
   function automatic int lane_depth(input int n_stages, input int lane);
      return n_stages - 1 - lane;
   endfunction

endpackage

// File: rtl/adcal_delay.sv
module adcal_delay #(
   parameter int W     = 2,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (DEPTH == 0) begin : g_wire
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] taps [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < DEPTH; k++) taps[k] <= '0;
            end else begin
               taps[0] <= d;
               for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
            end
         end
         assign q = taps[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/adcal_merge.sv
module adcal_merge #(
   parameter int NUM_STAGES = 4,
   parameter int CODE_W     = 2,
   parameter int OVERLAP    = 1,
   parameter int OUT_W      = 5
) (
   input  logic [NUM_STAGES*CODE_W-1:0] codes,
   output logic [OUT_W-1:0]             word
);

   localparam int SHIFT = CODE_W - OVERLAP;

   generate
      if (OVERLAP == 0) begin : g_concat
         // No redundancy: stage 0 lands in the top field.
         for (genvar i = 0; i < NUM_STAGES; i++) begin : g_field
            assign word[(NUM_STAGES-1-i)*CODE_W +: CODE_W] = codes[i*CODE_W +: CODE_W];
         end
      end else begin : g_overlap
         localparam int SUM_W = OUT_W + 1;
         localparam logic [OUT_W-1:0] WORD_MAX = '1;
         logic [SUM_W-1:0] acc;
         // Horner form: each step shifts the running sum by the stage's
         // effective resolution and adds the next code.
         always_comb begin
            acc = '0;
            for (int i = 0; i < NUM_STAGES; i++) begin
               acc = (acc << SHIFT) + SUM_W'(codes[i*CODE_W +: CODE_W]);
            end
         end
         assign word = acc[SUM_W-1] ? WORD_MAX : acc[OUT_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/adc_stage_combiner.sv
module adc_stage_combiner
   import adcal_pkg::*;
#(
   parameter int NUM_STAGES = 4,
   parameter int CODE_W     = 2,
   parameter int OVERLAP    = 1,
   localparam int OUT_W     = word_width(NUM_STAGES, CODE_W, OVERLAP)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [NUM_STAGES*CODE_W-1:0] stage_codes,
   output logic                         out_valid,
   output logic [OUT_W-1:0]             out_word
);

   localparam int BUS_W = NUM_STAGES * CODE_W;

   generate
      if (NUM_STAGES < 2) begin : g_bad_stages
         $error("adc_stage_combiner: NUM_STAGES must be at least 2");
      end
      if (CODE_W < 1) begin : g_bad_width
         $error("adc_stage_combiner: CODE_W must be at least 1");
      end
      if (OVERLAP < 0 || OVERLAP >= CODE_W) begin : g_bad_overlap
         $error("adc_stage_combiner: OVERLAP must lie in [0, CODE_W-1]");
      end
   endgenerate

   logic [BUS_W-1:0] aligned;
   logic             aligned_vld;
   logic [OUT_W-1:0] merged;

   // Lane i waits NUM_STAGES-1-i cycles so it meets the last stage's code.
   generate
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_lane
         adcal_delay #(
            .W     (CODE_W),
            .DEPTH (lane_depth(NUM_STAGES, i))
         ) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (stage_codes[i*CODE_W +: CODE_W]),
            .q     (aligned[i*CODE_W +: CODE_W])
         );
      end
   endgenerate

   adcal_delay #(
      .W     (1),
      .DEPTH (NUM_STAGES - 1)
   ) u_vld_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (in_valid),
      .q     (aligned_vld)
   );

   adcal_merge #(
      .NUM_STAGES (NUM_STAGES),
      .CODE_W     (CODE_W),
      .OVERLAP    (OVERLAP),
      .OUT_W      (OUT_W)
   ) u_merge (
      .codes (aligned),
      .word  (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= aligned_vld;
         if (aligned_vld) out_word <= merged;
      end
   end

endmodule

// File: rtl/adcal_checker.sv
module adcal_checker #(
   parameter int NUM_STAGES = 4,
   parameter int CODE_W     = 2,
   parameter int OVERLAP    = 1,
   parameter int OUT_W      = 5
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         in_valid,
   input logic [NUM_STAGES*CODE_W-1:0] stage_codes,
   input logic                         out_valid,
   input logic [OUT_W-1:0]             out_word
);

   localparam logic [OUT_W-1:0] TOP_WORD = '1;

   // Per-age flags: a sample is still valid / all lanes seen so far zero / all ones.
   logic [NUM_STAGES-1:0] vh;
   logic [NUM_STAGES-1:0] za;
   logic [NUM_STAGES-1:0] ma;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vh <= '0;
         za <= '0;
         ma <= '0;
      end else begin
         vh[0] <= in_valid;
         za[0] <= (stage_codes[0 +: CODE_W] == '0);
         ma[0] <= &stage_codes[0 +: CODE_W];
         for (int k = 1; k < NUM_STAGES; k++) begin
            vh[k] <= vh[k-1];
            za[k] <= za[k-1] && (stage_codes[k*CODE_W +: CODE_W] == '0);
            ma[k] <= ma[k-1] && (&stage_codes[k*CODE_W +: CODE_W]);
         end
      end
   end

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_word == '0));

   p_fill_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vh[NUM_STAGES-1]);

   p_zero_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vh[NUM_STAGES-1] && za[NUM_STAGES-1]) |-> out_word == '0);

   p_clip_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vh[NUM_STAGES-1] && ma[NUM_STAGES-1]) |-> out_word == TOP_WORD);

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_word));

endmodule

bind adc_stage_combiner adcal_checker #(
   .NUM_STAGES (NUM_STAGES),
   .CODE_W     (CODE_W),
   .OVERLAP    (OVERLAP),
   .OUT_W      (OUT_W)
) u_chk (.*);

// File: tb/adc_stage_combiner_test.sv
`timescale 1ns/1ps
module adc_stage_combiner_test;

   localparam int NS    = 4;
   localparam int CW    = 2;
   localparam int OV    = 1;
   localparam int OW    = 5;
   localparam int WMAX  = 31;
   localparam int SLOTS = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [NS*CW-1:0] stage_codes = '0;
   logic            out_valid;
   logic [OW-1:0]   out_word;

   always #2.5 clk = ~clk;

   adc_stage_combiner #(.NUM_STAGES(NS), .CODE_W(CW), .OVERLAP(OV)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .stage_codes (stage_codes),
      .out_valid   (out_valid),
      .out_word    (out_word)
   );

   typedef struct { int exp; int due; string req; } item_t;
   item_t q[$];

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit mon_on = 1'b0;
   int last_word = 0;

   logic [NS*CW-1:0] slot_code [SLOTS];
   bit               slot_vld  [SLOTS];
   int               slot_exp  [SLOTS];
   string            slot_req  [SLOTS];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic [NS*CW-1:0] pk(input int a, input int b, input int c, input int d);
      return {CW'(d), CW'(c), CW'(b), CW'(a)};
   endfunction

   // R4/R5: weighted sum with stage 0 heaviest, then clip.
   function automatic int direct_word(input logic [NS*CW-1:0] bus);
      int acc = 0;
      for (int i = 0; i < NS; i++) acc = acc * 2 + int'(bus[i*CW +: CW]);
      return (acc > WMAX) ? WMAX : acc;
   endfunction

   // R8: 1.5-bit stages with decision levels shifted by off, 2-bit last stage.
   function automatic logic [NS*CW-1:0] stage_model(input real vin, input real off);
      logic [NS*CW-1:0] bus = '0;
      real r = vin;
      int d;
      int c;
      for (int i = 0; i < NS-1; i++) begin
         if (r > 0.25 + off) d = 1;
         else if (r < -0.25 + off) d = -1;
         else d = 0;
         bus[i*CW +: CW] = CW'(d + 1);
         r = 2.0 * r - real'(d);
      end
      c = int'($floor((r + 1.0) * 2.0));
      if (c < 0) c = 0;
      if (c > 3) c = 3;
      bus[(NS-1)*CW +: CW] = CW'(c);
      return bus;
   endfunction

   function automatic int analog_word(input real vin);
      int w = int'($floor(16.0 * (vin + 1.0)));
      if (w < 0) w = 0;
      if (w > WMAX) w = WMAX;
      return w;
   endfunction

   task automatic set_direct(input int s, input logic [NS*CW-1:0] bus, input string req);
      slot_vld[s]  = 1'b1;
      slot_code[s] = bus;
      slot_exp[s]  = direct_word(bus);
      slot_req[s]  = req;
   endtask

   task automatic set_gap(input int s);
      slot_vld[s]  = 1'b0;
      slot_code[s] = pk((s*5) % 4, (s*3+1) % 4, (s+2) % 4, (s*7+3) % 4);
      slot_exp[s]  = 0;
      slot_req[s]  = "gap";
   endtask

   task automatic set_analog(input int s, input int k, input real off, input string req);
      real v = (real'(k) + 0.5) / 16.0 - 1.0;
      slot_vld[s]  = 1'b1;
      slot_code[s] = stage_model(v, off);
      slot_exp[s]  = analog_word(v);
      slot_req[s]  = req;
   endtask

   task automatic fill();
      set_direct(0, pk(1,1,1,2), "R4");
      set_direct(1, pk(0,0,0,0), "R4");
      set_direct(2, pk(2,2,2,3), "R4");
      set_direct(3, pk(3,3,3,3), "R5");
      set_direct(4, pk(3,0,0,0), "R4");
      set_direct(5, pk(0,3,3,3), "R4");
      set_direct(6, pk(3,3,0,0), "R5");
      set_direct(7, pk(2,1,0,3), "R3");
      set_direct(8, pk(0,1,2,3), "R3");
      for (int s = 9; s < 12; s++) set_gap(s);
      set_direct(12, pk(1,0,2,1), "R3");
      for (int s = 13; s < 16; s++) set_gap(s);
      for (int k = 0; k < 32; k++) begin
         if (k % 3 == 0)      set_analog(16 + k, k, 0.0, "R7");
         else if (k % 3 == 1) set_analog(16 + k, k, 0.1875, "R8");
         else                 set_analog(16 + k, k, -0.1875, "R8");
      end
      for (int s = 48; s < 60; s++)
         set_analog(s, (s * 7) % 32, (s % 2 == 1) ? 0.1875 : -0.1875, "R8");
      for (int s = 60; s < SLOTS; s++) set_gap(s);
   endtask

   // Driver: lane i carries the code of the sample presented i cycles earlier.
   task automatic drive(input int s);
      logic [NS*CW-1:0] bus = '0;
      for (int i = 0; i < NS; i++) begin
         int src = s - i;
         if (src >= 0 && src < SLOTS) bus[i*CW +: CW] = slot_code[src][i*CW +: CW];
      end
      stage_codes = bus;
      in_valid = (s < SLOTS) ? slot_vld[s] : 1'b0;
      if (s < SLOTS && slot_vld[s]) begin
         item_t it;
         it.exp = slot_exp[s];
         it.due = cyc + NS;
         it.req = slot_req[s];
         q.push_back(it);
      end
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         if (out_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, "R2", 1, 0);
            end else begin
               item_t it;
               it = q.pop_front();
               chk(int'(out_word) == it.exp, it.req, int'(out_word), it.exp);
               chk(cyc == it.due, "R2", cyc, it.due);
            end
            last_word = int'(out_word);
         end else begin
            chk(int'(out_word) == last_word, "R6", int'(out_word), last_word);
         end
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(5.0 * 20000);
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      fill();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
      chk(out_word == '0, "R1", int'(out_word), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      for (int s = 0; s < SLOTS + NS + 2; s++) begin
         drive(s);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (NS + 2) @(negedge clk);
      chk(q.size() == 0, "R2", q.size(), 0);
      summary();
      $finish;
   end

endmodule